// File: doc/BRIEF.md
# Asymmetric Decode Slot Steering

This block steers a three-slot parallel decoder. Slot 0 is the wide decoder and can produce up to four uops. Slots 1 and 2 are narrow and produce one uop each. Each cycle an aligned source presents up to three instructions in program order, each tagged with the number of uops it expands to. The block decides which slots issue, reports how many instructions the source should consume, and gives the uop count each issuing slot produces.

An instruction that is too large for the wide decoder is handed to a microcode sequencer. Only the leading slot can do this hand-off. The sequencer then emits the stored uops in groups of up to three per cycle, and the ordinary decoders stay idle. When an instruction in a narrow slot needs more than one uop, that slot and every slot after it are held. The source advances only past the instructions that issued, so the held instruction reaches slot 0 on the next cycle. A downstream stall freezes the whole block.

Top module: `dec_steer`

## Requirements
- R1: Slot 0 issues a valid instruction whose uop count is 1 to 4, and `slot_uops` bits [4:0] then show that count. An idle slot shows 0.
- R2: Slot 1 (uop count in `in_uops` bits [9:5]) and slot 2 (bits [14:10]) issue only an instruction whose count is exactly 1, and show a count of 1 when they issue.
- R3: An instruction needing more than one uop in slot 1 or 2 is not issued and not consumed, so a source that advances by `consume_cnt` presents it in slot 0 on the next cycle.
- R4: When slot 0 holds an instruction needing more than 4 uops, no slot issues, `consume_cnt` is 1, and `ucode_active` rises on the next cycle. An instruction of that size in slot 1 or 2 never starts the sequencer.
- R5: While `ucode_active` is high, no slot issues, `consume_cnt` is 0, and each unstalled cycle `ucode_grp` emits min(3, remaining) uops, so the groups add up to the instruction's uop count.
- R6: While `stall` is high, no slot issues, `consume_cnt` and `ucode_grp` are 0, and the sequencer's remaining count is held. A stall on the cycle a large instruction sits in slot 0 does not start the sequencer.
- R7: Slots issue strictly in order. Once a slot does not issue, no later slot issues in that cycle.
- R8: Outside a sequencer start, `consume_cnt` equals the number of leading slots that issued.
- R9: `ucode_active` stays high through the cycle that emits the last group and is low on the following cycle, when normal issue resumes in slot 0.
- R10: While `rst_n` is low, no slot issues, `consume_cnt` is 0, and after reset `ucode_active` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 3 | Valid bit per slot; bit i is slot i |
| in_uops | input | 15 | Uop count per slot, 5 bits each; slot i at bits [5i+4:5i] |
| stall | input | 1 | Downstream stall; freezes the block |
| issue_en | output | 3 | Issue enable per slot |
| consume_cnt | output | 2 | Instructions the source advances by |
| slot_uops | output | 15 | Uop count produced per slot, same layout as `in_uops` |
| ucode_active | output | 1 | Microcode sequencer is streaming |
| ucode_grp | output | 2 | Uops the sequencer emits this cycle |

## Verification
The assertions assume that the source presents valid instructions as a contiguous prefix starting at slot 0, that every valid instruction needs at least one uop, and that the source advances exactly by `consume_cnt`. The table-driven stimulus only uses prefix-valid patterns with nonzero counts. The directed sequences model the source by shifting a small instruction stream by the reported consume count. Stalls are raised both during a microcode stream and on the cycle a large instruction reaches slot 0, so the frozen-counter and no-start cases are both covered.

// File: rtl/dec_steer_pkg.sv
// Shared constants and helpers for the decode steering block.
// Assumes: uop counts are unsigned and nonzero for valid instructions.
package dec_steer_pkg;

    // Default geometry of the decoder array.
    localparam int unsigned DEF_SLOTS     = 3;
    localparam int unsigned DEF_UOP_W     = 5;
    localparam int unsigned DEF_LEAD_MAX  = 4;
    localparam int unsigned DEF_UCODE_RATE = 3;

    // Width able to hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dec_slot_gate.sv
// Per-slot acceptance gate.
// The lead slot accepts an instruction of 1..LEAD_MAX uops. A trailing slot
// accepts only a single-uop instruction, and only if the slot before it issued.
// Assumes: the caller ties prev_ok high for the lead slot.
module dec_slot_gate #(
    parameter int unsigned UOP_W    = 5,
    parameter int unsigned LEAD_MAX = 4,
    parameter bit          IS_LEAD  = 1'b0
) (
    input  logic             in_valid,
    input  logic [UOP_W-1:0] in_uops,
    input  logic             prev_ok,
    output logic             slot_ok
);

    generate
        if (IS_LEAD) begin : g_lead
            // Wide decoder: any count from one up to its limit.
            always_comb begin
                slot_ok = prev_ok && in_valid && (in_uops != '0)
                          && (in_uops <= UOP_W'(LEAD_MAX));
            end
        end else begin : g_trail
            // Narrow decoder: exactly one uop, in order behind its neighbour.
            always_comb begin
                slot_ok = prev_ok && in_valid && (in_uops == UOP_W'(1));
            end
        end
    endgenerate

endmodule

// File: rtl/dec_ucode_seq.sv
// Microcode sequencer control.
// Starts when the lead slot holds an instruction larger than the wide decoder
// can handle, loads a remaining-uop counter, and drains it RATE per unstalled
// cycle. Active is the counter being nonzero, so it drops on the cycle after
// the last group is emitted.
// Assumes: a start is only taken when the block is not already streaming.
module dec_ucode_seq #(
    parameter int unsigned UOP_W    = 5,
    parameter int unsigned LEAD_MAX = 4,
    parameter int unsigned RATE     = 3,
    localparam int unsigned GRP_W   = dec_steer_pkg::cnt_width(RATE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             lead_valid,
    input  logic [UOP_W-1:0] lead_uops,
    output logic             active,
    output logic             start,
    output logic [GRP_W-1:0] grp
);

    logic [UOP_W-1:0] rem_q;
    logic             last_grp;

    // Streaming state and hand-off decision.
    always_comb begin
        active   = (rem_q != '0);
        last_grp = (rem_q <= UOP_W'(RATE));
        start    = rst_n && !stall && !active && lead_valid
                   && (lead_uops > UOP_W'(LEAD_MAX));
    end

    // Group size emitted this cycle: min(RATE, remaining), zero when stalled.
    always_comb begin
        if (!active || stall) begin
            grp = '0;
        end else if (last_grp) begin
            grp = GRP_W'(rem_q);
        end else begin
            grp = GRP_W'(RATE);
        end
    end

    // Remaining-uop counter: load on start, drain while streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (start) begin
            rem_q <= lead_uops;
        end else if (active && !stall) begin
            rem_q <= last_grp ? '0 : (rem_q - UOP_W'(RATE));
        end
    end

endmodule

// File: rtl/dec_steer.sv
// Asymmetric decode slot steering, top level.
// Decides per cycle which of the aligned slots issue (one wide lead slot,
// narrow trailing slots), how many instructions the source consumes, and
// when to hand a large instruction to the microcode sequencer.
// Assumes: valid bits form a prefix from slot 0, valid counts are nonzero,
// and the source advances by consume_cnt each clock.
module dec_steer #(
    parameter int unsigned NUM_SLOTS  = dec_steer_pkg::DEF_SLOTS,
    parameter int unsigned UOP_W      = dec_steer_pkg::DEF_UOP_W,
    parameter int unsigned LEAD_MAX   = dec_steer_pkg::DEF_LEAD_MAX,
    parameter int unsigned UCODE_RATE = dec_steer_pkg::DEF_UCODE_RATE,
    localparam int unsigned CNT_W     = dec_steer_pkg::cnt_width(NUM_SLOTS),
    localparam int unsigned GRP_W     = dec_steer_pkg::cnt_width(UCODE_RATE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       in_valid,
    input  logic [NUM_SLOTS*UOP_W-1:0] in_uops,
    input  logic                       stall,
    output logic [NUM_SLOTS-1:0]       issue_en,
    output logic [CNT_W-1:0]           consume_cnt,
    output logic [NUM_SLOTS*UOP_W-1:0] slot_uops,
    output logic                       ucode_active,
    output logic [GRP_W-1:0]           ucode_grp
);

    logic [NUM_SLOTS-1:0] slot_ok;
    logic                 ucode_start;
    logic                 run;

    // Microcode sequencer fed from the lead slot only.
    dec_ucode_seq #(
        .UOP_W    (UOP_W),
        .LEAD_MAX (LEAD_MAX),
        .RATE     (UCODE_RATE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .lead_valid (in_valid[0]),
        .lead_uops  (in_uops[UOP_W-1:0]),
        .active     (ucode_active),
        .start      (ucode_start),
        .grp        (ucode_grp)
    );

    // Chain of slot gates, each enabled by the one before it.
    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            if (i == 0) begin : g_first
                dec_slot_gate #(
                    .UOP_W    (UOP_W),
                    .LEAD_MAX (LEAD_MAX),
                    .IS_LEAD  (1'b1)
                ) u_gate (
                    .in_valid (in_valid[i]),
                    .in_uops  (in_uops[i*UOP_W +: UOP_W]),
                    .prev_ok  (1'b1),
                    .slot_ok  (slot_ok[i])
                );
            end else begin : g_next
                dec_slot_gate #(
                    .UOP_W    (UOP_W),
                    .LEAD_MAX (LEAD_MAX),
                    .IS_LEAD  (1'b0)
                ) u_gate (
                    .in_valid (in_valid[i]),
                    .in_uops  (in_uops[i*UOP_W +: UOP_W]),
                    .prev_ok  (slot_ok[i-1]),
                    .slot_ok  (slot_ok[i])
                );
            end
        end
    endgenerate

    // Ordinary decoders run only out of reset, unstalled and not streaming.
    always_comb begin
        run = rst_n && !stall && !ucode_active;
    end

    // Issue enables and per-slot uop counts.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            issue_en[i] = run && slot_ok[i];
            slot_uops[i*UOP_W +: UOP_W] = issue_en[i] ? in_uops[i*UOP_W +: UOP_W] : '0;
        end
    end

    // Consumed count: the hand-off takes one, otherwise count issued slots.
    always_comb begin
        consume_cnt = '0;
        if (ucode_start) begin
            consume_cnt = CNT_W'(1);
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                consume_cnt = consume_cnt + CNT_W'(issue_en[i]);
            end
        end
    end

endmodule

// File: rtl/dec_steer_chk.sv
// Assertion checker for dec_steer, bound to every instance.
// Assumes the input conventions stated on the top module.
module dec_steer_chk #(
    parameter int unsigned NUM_SLOTS  = 3,
    parameter int unsigned UOP_W      = 5,
    parameter int unsigned LEAD_MAX   = 4,
    parameter int unsigned UCODE_RATE = 3,
    localparam int unsigned CNT_W     = dec_steer_pkg::cnt_width(NUM_SLOTS),
    localparam int unsigned GRP_W     = dec_steer_pkg::cnt_width(UCODE_RATE)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLOTS-1:0]       in_valid,
    input logic [NUM_SLOTS*UOP_W-1:0] in_uops,
    input logic                       stall,
    input logic [NUM_SLOTS-1:0]       issue_en,
    input logic [CNT_W-1:0]           consume_cnt,
    input logic [NUM_SLOTS*UOP_W-1:0] slot_uops,
    input logic                       ucode_active,
    input logic [GRP_W-1:0]           ucode_grp
);

    // R1: the wide slot only ever produces 1..LEAD_MAX uops.
    p_lead_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en[0] |-> (slot_uops[UOP_W-1:0] != '0)
                        && (slot_uops[UOP_W-1:0] <= UOP_W'(LEAD_MAX)));

    // R2 and R7: narrow slots produce one uop and issue only behind their neighbour.
    generate
        for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_trail
            p_narrow_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
                issue_en[i] |-> (slot_uops[i*UOP_W +: UOP_W] == UOP_W'(1)));
            p_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
                issue_en[i] |-> issue_en[i-1]);
        end
    endgenerate

    // R4: a large instruction in the lead slot starts streaming next cycle.
    p_ucode_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !ucode_active && in_valid[0]
         && (in_uops[UOP_W-1:0] > UOP_W'(LEAD_MAX))) |=> ucode_active);

    // R5: streaming silences the ordinary decoders and caps the group size.
    p_ucode_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ucode_active |-> (issue_en == '0) && (consume_cnt == '0)
                         && (ucode_grp <= GRP_W'(UCODE_RATE)));

    // R6: a stall freezes issue, consumption and the group output.
    p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (issue_en == '0) && (consume_cnt == '0) && (ucode_grp == '0));

    // R8: consumption matches the number of issued slots whenever any issue.
    p_consume_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en != '0) |-> (consume_cnt == CNT_W'($countones(issue_en))));

    // R9: streaming only ends on a cycle that emitted a group.
    p_ucode_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ucode_active && stall) |=> ucode_active);

endmodule

bind dec_steer dec_steer_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .UOP_W      (UOP_W),
    .LEAD_MAX   (LEAD_MAX),
    .UCODE_RATE (UCODE_RATE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_uops      (in_uops),
    .stall        (stall),
    .issue_en     (issue_en),
    .consume_cnt  (consume_cnt),
    .slot_uops    (slot_uops),
    .ucode_active (ucode_active),
    .ucode_grp    (ucode_grp)
);

// File: tb/dec_steer_tb.sv
module dec_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  in_valid;
    logic [14:0] in_uops;
    logic        stall;
    logic [2:0]  issue_en;
    logic [1:0]  consume_cnt;
    logic [14:0] slot_uops;
    logic        ucode_active;
    logic [1:0]  ucode_grp;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;  // 50 MHz

    dec_steer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_uops      (in_uops),
        .stall        (stall),
        .issue_en     (issue_en),
        .consume_cnt  (consume_cnt),
        .slot_uops    (slot_uops),
        .ucode_active (ucode_active),
        .ucode_grp    (ucode_grp)
    );

    // Entry: {stall, valid[2:0], u0, u1, u2, exp_issue[2:0], exp_consume[1:0]}
    localparam int NVEC = 12;
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 3'b111, 5'd1, 5'd1, 5'd1, 3'b111, 2'd3},  // R1 R2 R8
        {1'b0, 3'b111, 5'd4, 5'd1, 5'd1, 3'b111, 2'd3},  // R1 lead at limit
        {1'b0, 3'b111, 5'd2, 5'd2, 5'd1, 3'b001, 2'd1},  // R3 slot 1 heavy
        {1'b0, 3'b111, 5'd1, 5'd1, 5'd3, 3'b011, 2'd2},  // R3 slot 2 heavy
        {1'b0, 3'b111, 5'd3, 5'd1, 5'd2, 3'b011, 2'd2},  // R3 R8
        {1'b0, 3'b001, 5'd2, 5'd0, 5'd0, 3'b001, 2'd1},  // R1 single valid
        {1'b0, 3'b011, 5'd1, 5'd1, 5'd0, 3'b011, 2'd2},  // R8 two valid
        {1'b0, 3'b000, 5'd0, 5'd0, 5'd0, 3'b000, 2'd0},  // R8 empty
        {1'b1, 3'b111, 5'd1, 5'd1, 5'd1, 3'b000, 2'd0},  // R6 stall
        {1'b0, 3'b111, 5'd1, 5'd4, 5'd1, 3'b001, 2'd1},  // R7 blocked behind
        {1'b0, 3'b111, 5'd2, 5'd1, 5'd4, 3'b011, 2'd2},  // R2 R7
        {1'b0, 3'b111, 5'd1, 5'd6, 5'd1, 3'b001, 2'd1}   // R4 large in slot 1
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic [2:0] v,
                         input int u0, input int u1, input int u2);
        @(negedge clk);
        stall    = st;
        in_valid = v;
        in_uops  = {5'(u2), 5'(u1), 5'(u0)};
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stall = 1'b0; in_valid = 3'b111; in_uops = {5'd1, 5'd1, 5'd7};
        // R10: reset holds issue and consumption low.
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 issue", int'(issue_en), 0);
        chk("R10 consume", int'(consume_cnt), 0);
        chk("R10 active", int'(ucode_active), 0);
        rst_n = 1'b1;
        in_valid = 3'b000; in_uops = '0;

        // Table walk: ordinary decode patterns, no sequencer start.
        for (int k = 0; k < NVEC; k++) begin
            logic [23:0] e;
            e = VEC[k];
            drive(e[23], e[22:20], int'(e[19:15]), int'(e[14:10]), int'(e[9:5]));
            chk($sformatf("R1/R2/R3/R7/R8 vec%0d issue", k), int'(issue_en), int'(e[4:2]));
            chk($sformatf("R8 vec%0d consume", k), int'(consume_cnt), int'(e[1:0]));
            for (int s = 0; s < 3; s++) begin
                int expu;
                expu = e[2+s] ? int'(e[19-5*s -: 5]) : 0;
                chk($sformatf("R1/R2 vec%0d slot%0d uops", k, s),
                    int'(slot_uops[5*s +: 5]), expu);
            end
        end
        @(negedge clk);
        chk("R4 slot1 large no start", int'(ucode_active), 0);

        // R3: stream [1,3,1,1]; the held 3-uop instruction moves to slot 0.
        drive(1'b0, 3'b111, 1, 3, 1);
        chk("R3 first issue", int'(issue_en), 1);
        chk("R3 first consume", int'(consume_cnt), 1);
        drive(1'b0, 3'b111, 3, 1, 1);
        chk("R3 shifted issue", int'(issue_en), 7);
        chk("R3 shifted lead uops", int'(slot_uops[4:0]), 3);

        // R4 R5 R6 R9: 7-uop instruction, stall in the middle of the stream.
        drive(1'b0, 3'b111, 7, 1, 1);
        chk("R4 start issue", int'(issue_en), 0);
        chk("R4 start consume", int'(consume_cnt), 1);
        chk("R4 not yet active", int'(ucode_active), 0);
        drive(1'b0, 3'b111, 1, 1, 1);
        chk("R4 active", int'(ucode_active), 1);
        chk("R5 grp1", int'(ucode_grp), 3);
        chk("R5 quiet issue", int'(issue_en), 0);
        chk("R5 quiet consume", int'(consume_cnt), 0);
        drive(1'b1, 3'b111, 1, 1, 1);
        chk("R6 stall grp", int'(ucode_grp), 0);
        chk("R6 stall active", int'(ucode_active), 1);
        drive(1'b0, 3'b111, 1, 1, 1);
        chk("R6 R5 grp2 after stall", int'(ucode_grp), 3);
        drive(1'b0, 3'b111, 1, 1, 1);
        chk("R5 grp3 remainder", int'(ucode_grp), 1);
        chk("R9 active on last", int'(ucode_active), 1);
        drive(1'b0, 3'b111, 1, 1, 1);
        chk("R9 inactive after", int'(ucode_active), 0);
        chk("R9 resume issue", int'(issue_en), 7);
        chk("R9 resume consume", int'(consume_cnt), 3);

        // R6: stall while a large instruction sits in slot 0 starts nothing.
        drive(1'b1, 3'b001, 9, 0, 0);
        chk("R6 stalled start consume", int'(consume_cnt), 0);
        drive(1'b0, 3'b000, 0, 0, 0);
        chk("R6 no start after stall", int'(ucode_active), 0);

        // R5 boundary: 5 uops stream as 3 then 2.
        drive(1'b0, 3'b011, 5, 1, 0);
        chk("R4 five consume", int'(consume_cnt), 1);
        drive(1'b0, 3'b001, 1, 0, 0);
        chk("R5 five grp1", int'(ucode_grp), 3);
        drive(1'b0, 3'b001, 1, 0, 0);
        chk("R5 five grp2", int'(ucode_grp), 2);
        drive(1'b0, 3'b001, 1, 0, 0);
        chk("R9 five done", int'(ucode_active), 0);
        chk("R9 five resume", int'(issue_en), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule